// File: doc/BRIEF.md
# Shared Cache Maintenance Command Queue

This block is the register front end of an outer-cache maintenance engine that several CPUs share. Each CPU issues commands over one word-wide register port. Every access carries the CPU's identifier. To register a command, a CPU writes a mode word, then an optional start address and byte count, and then reads its own result register. The first mode write takes an exclusive lock on the shared staging registers. The holder's result read ends the sequence. That read places the command in a FIFO, or reports that the FIFO is full, and in both cases it frees the lock.

Queued commands run one at a time, in the order they were accepted. A simple executor stands in for the real cache. It walks one cache line every `CYC_PER_LINE` cycles and shows the current line address and operation on its outputs. Result and completion status are kept per CPU, so each CPU sees only the outcome of its own commands.

A separate immediate-primitive register accepts a drain request. A later read of that register is held off with `req_wait` until the queue and the executor are both idle.

Top module: `cmaint_queue`

## Requirements
- R1: After reset, for every CPU, the status register (offset 0x260) and the result register (offset 0x25C) read 0. `exec_busy` is low and the lock is free.
- R2: A mode write (offset 0x248) from any CPU while the lock is free grants that CPU the lock. While another CPU holds it, a mode, address (0x24C) or size (0x250) write from a CPU is dropped and sets bit 0 of that CPU's result register. The result register then reads 0x1, and the holder's staged command is unaffected.
- R3: A result-register read by the lock holder releases the lock. It returns 0x0 and appends the staged command to the FIFO when the FIFO has room. A different CPU may take the lock right afterwards.
- R4: When the FIFO already holds `DEPTH` entries, the holder's result read returns 0x3 (bit 1 = full, bit 0 = failed). The command is not queued, and the lock is still released.
- R5: In the mode word, bits [18:17] give the scope (1 = whole cache, any other value = address range), bit 15 requests completion notice and bits [1:0] give the operation. A range command covers ceil(size/`LINE_BYTES`) lines, with a minimum of 1. The executor stays busy for lines × `CYC_PER_LINE` cycles and starts on the clock edge after the acceptance edge, provided the FIFO was empty and the executor was idle.
- R6: A whole-cache command covers `SETS` × `WAYS` lines starting at line address 0. Any address or size written for it is ignored.
- R7: Accepted commands execute strictly in acceptance order, with one command at a time.
- R8: Status bit 2 of a CPU sets when one of that CPU's notifying commands finishes, and never for commands that did not request notice or that came from another CPU. Writing 1 to bit 2 clears it.
- R9: Status bit 0 reads 1 while the FIFO holds entries or the executor is busy. Status bit 1 reads 1 only for the CPU whose command is currently executing.
- R10: Writing 0x8 (drain) to the primitive register (offset 0x244) makes a later read of that register stall through `req_wait` until the FIFO is empty and the executor is idle. Otherwise a read returns the last code written, with no stall.
- R11: While a command runs, `exec_addr` starts at the start address rounded down to a line boundary and advances by `LINE_BYTES` per line. `exec_op` shows the command's operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request, held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CW | Identifier of the requesting CPU |
| req_addr | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the cycle the access is accepted |
| req_wait | output | 1 | Stall: the access is not accepted this cycle |
| exec_busy | output | 1 | Executor is processing a command |
| exec_op | output | 2 | Operation of the running command |
| exec_addr | output | AW | Line address currently being processed |

## Verification
A corrupted lock owner shows up on the next contended sequence. The wrong CPU reads 0x1 from its result register, or a staged size from the wrong CPU changes the measured busy length on the following run. A FIFO pointer or count error shows up as an out-of-order start address on `exec_addr`, as a missing run, or as a result of 0x3 one entry early or late. These show up within one command's execution time. A line-counter error changes the busy length by a whole multiple of `CYC_PER_LINE`, and it is measured exactly for every command.

// File: rtl/cmaint_queue.sv
module cmaint_queue #(
  parameter int NCPU         = 2,
  parameter int DEPTH        = 4,
  parameter int LINE_BYTES   = 32,
  parameter int CYC_PER_LINE = 2,
  parameter int SETS         = 8,
  parameter int WAYS         = 4,
  parameter int AW           = 32,
  localparam int CW          = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [CW-1:0] req_cpu,
  input  logic [11:0]   req_addr,
  input  logic [31:0]   req_wdata,
  output logic [31:0]   rd_data,
  output logic          req_wait,
  output logic          exec_busy,
  output logic [1:0]    exec_op,
  output logic [AW-1:0] exec_addr
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = PW + 1;
  localparam int LS   = $clog2(LINE_BYTES);
  localparam int SW   = $clog2(CYC_PER_LINE + 1);
  localparam logic [32:0] WHOLE_LINES = 33'(SETS * WAYS);
  localparam logic [11:0] OFF_PRIM = 12'h244, OFF_MODE = 12'h248, OFF_ADDR = 12'h24C,
                          OFF_SIZE = 12'h250, OFF_RES  = 12'h25C, OFF_STAT = 12'h260;

  logic          locked;
  logic [CW-1:0] owner;
  logic          st_whole, st_notify;
  logic [1:0]    st_op;
  logic [AW-1:0] st_addr;
  logic [31:0]   st_size;
  logic [1:0]    res [NCPU];
  logic [NCPU-1:0] done;
  logic [3:0]    prim_code;
  logic          drain_pend;

  logic [CW-1:0] q_cpu    [DEPTH];
  logic          q_whole  [DEPTH];
  logic          q_notify [DEPTH];
  logic [1:0]    q_op     [DEPTH];
  logic [AW-1:0] q_addr   [DEPTH];
  logic [31:0]   q_size   [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;

  logic          cur_notify;
  logic [CW-1:0] cur_cpu;
  logic [32:0]   lines_left;
  logic [SW-1:0] sub;

  wire acc      = req_valid && !req_wait;
  wire holder   = locked && owner == req_cpu;
  wire wr_mode  = acc && req_write && req_addr == OFF_MODE;
  wire wr_addr  = acc && req_write && req_addr == OFF_ADDR;
  wire wr_size  = acc && req_write && req_addr == OFF_SIZE;
  wire wr_prim  = acc && req_write && req_addr == OFF_PRIM;
  wire wr_stat  = acc && req_write && req_addr == OFF_STAT;
  wire rd_res   = acc && !req_write && req_addr == OFF_RES;
  wire full     = count == CNTW'(DEPTH);
  wire push     = rd_res && holder && !full;
  wire pop      = !exec_busy && count != '0;
  wire active   = exec_busy || count != '0;
  wire line_end = sub == SW'(CYC_PER_LINE - 1);
  wire finish   = exec_busy && line_end && lines_left == 33'd1;

  assign req_wait = req_valid && !req_write && req_addr == OFF_PRIM && drain_pend && active;

  logic [32:0]   head_lines;
  logic [AW-1:0] head_start;
  always_comb begin
    if (q_whole[rd_ptr])
      head_lines = WHOLE_LINES;
    else if (q_size[rd_ptr] == 32'd0)
      head_lines = 33'd1;
    else
      head_lines = ({1'b0, q_size[rd_ptr]} + 33'(LINE_BYTES - 1)) >> LS;
    head_start = q_whole[rd_ptr] ? '0 : (q_addr[rd_ptr] & ~AW'(LINE_BYTES - 1));
  end

  always_comb begin
    rd_data = '0;
    case (req_addr)
      OFF_PRIM: rd_data = {28'd0, prim_code};
      OFF_MODE: rd_data = {13'd0, 1'b0, st_whole, 1'b0, st_notify, 13'd0, st_op};
      OFF_RES:  rd_data = holder ? {30'd0, full, full} : {30'd0, res[req_cpu]};
      OFF_STAT: rd_data = {29'd0, done[req_cpu], exec_busy && cur_cpu == req_cpu, active};
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      owner     <= '0;
      st_whole  <= 1'b0;
      st_notify <= 1'b0;
      st_op     <= '0;
      st_addr   <= '0;
      st_size   <= '0;
      for (int i = 0; i < NCPU; i++) res[i] <= '0;
    end else begin
      if (wr_mode) begin
        if (!locked || holder) begin
          locked    <= 1'b1;
          owner     <= req_cpu;
          st_whole  <= req_wdata[18:17] == 2'd1;
          st_notify <= req_wdata[15];
          st_op     <= req_wdata[1:0];
          res[req_cpu] <= 2'b00;
        end else begin
          res[req_cpu] <= 2'b01;
        end
      end
      if (wr_addr) begin
        if (holder) st_addr <= req_wdata[AW-1:0];
        else        res[req_cpu] <= 2'b01;
      end
      if (wr_size) begin
        if (holder) st_size <= req_wdata;
        else        res[req_cpu] <= 2'b01;
      end
      if (rd_res && holder) begin
        locked       <= 1'b0;
        res[req_cpu] <= {full, full};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_cpu[wr_ptr]    <= req_cpu;
      q_whole[wr_ptr]  <= st_whole;
      q_notify[wr_ptr] <= st_notify;
      q_op[wr_ptr]     <= st_op;
      q_addr[wr_ptr]   <= st_addr;
      q_size[wr_ptr]   <= st_size;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNTW'(push) - CNTW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_busy  <= 1'b0;
      exec_op    <= '0;
      exec_addr  <= '0;
      cur_cpu    <= '0;
      cur_notify <= 1'b0;
      lines_left <= '0;
      sub        <= '0;
      done       <= '0;
      prim_code  <= '0;
      drain_pend <= 1'b0;
    end else begin
      if (pop) begin
        exec_busy  <= 1'b1;
        exec_op    <= q_op[rd_ptr];
        exec_addr  <= head_start;
        cur_cpu    <= q_cpu[rd_ptr];
        cur_notify <= q_notify[rd_ptr];
        lines_left <= head_lines;
        sub        <= '0;
      end else if (exec_busy) begin
        if (line_end) begin
          sub <= '0;
          if (lines_left == 33'd1) begin
            exec_busy <= 1'b0;
          end else begin
            lines_left <= lines_left - 33'd1;
            exec_addr  <= exec_addr + AW'(LINE_BYTES);
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
      if (wr_stat && req_wdata[2]) done[req_cpu] <= 1'b0;
      if (finish && cur_notify)    done[cur_cpu] <= 1'b1;
      if (wr_prim) prim_code <= req_wdata[3:0];
      if (wr_prim && req_wdata[3:0] == 4'h8) drain_pend <= 1'b1;
      else if (!active)                      drain_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/cmaint_queue_chk.sv
module cmaint_queue_chk #(
  parameter int CW         = 1,
  parameter int CNTW       = 3,
  parameter int DEPTH      = 4,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [CW-1:0]   req_cpu,
  input logic [11:0]     req_addr,
  input logic            req_wait,
  input logic            exec_busy,
  input logic [AW-1:0]   exec_addr,
  input logic            locked,
  input logic [CW-1:0]   owner,
  input logic [CNTW-1:0] count
);
  a_r2_grant_free_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_wait && req_write && req_addr == 12'h248 && !locked)
    |=> (locked && owner == $past(req_cpu)));

  a_r3_holder_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_wait && !req_write && req_addr == 12'h25C && locked && owner == req_cpu)
    |=> !locked);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));

  a_r7_start_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_busy) |-> $past(count) != '0);

  a_r10_stall_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_wait) && req_valid) |-> !exec_busy);

  a_r11_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_busy && $past(exec_busy) && exec_addr != $past(exec_addr))
    |-> exec_addr == $past(exec_addr) + AW'(LINE_BYTES));
endmodule

bind cmaint_queue cmaint_queue_chk #(
  .CW(CW), .CNTW(CNTW), .DEPTH(DEPTH), .AW(AW), .LINE_BYTES(LINE_BYTES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_cpu(req_cpu), .req_addr(req_addr), .req_wait(req_wait),
  .exec_busy(exec_busy), .exec_addr(exec_addr), .locked(locked),
  .owner(owner), .count(count)
);

// File: tb/cmaint_queue_tb_top.sv
module cmaint_queue_tb_top;
  localparam int NCPU = 2, DEPTH = 4, LINE = 32, CPL = 2, SETS = 8, WAYS = 4, AW = 32;
  localparam logic [11:0] PRIM = 12'h244, MODE = 12'h248, ADDR = 12'h24C,
                          SIZE = 12'h250, RES = 12'h25C, STAT = 12'h260;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [0:0] req_cpu = '0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rd_data;
  logic req_wait, exec_busy;
  logic [1:0] exec_op;
  logic [AW-1:0] exec_addr;
  int nvec = 0, nerr = 0;

  always #4 clk = ~clk;

  cmaint_queue #(.NCPU(NCPU), .DEPTH(DEPTH), .LINE_BYTES(LINE), .CYC_PER_LINE(CPL),
                 .SETS(SETS), .WAYS(WAYS), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .req_wait(req_wait), .exec_busy(exec_busy),
    .exec_op(exec_op), .exec_addr(exec_addr));

  function automatic int lines_of(input bit whole, input int unsigned size);
    if (whole) return SETS * WAYS;
    if (size == 0) return 1;
    return (size + LINE - 1) / LINE;
  endfunction

  function automatic logic [31:0] mode_word(input bit whole, input bit notify, input int op);
    return (whole ? 32'h0002_0000 : 32'h0) | (notify ? 32'h8000 : 32'h0) | 32'(op & 3);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus(input bit w, input int cpu, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] r, output int waits);
    @(negedge clk);
    req_valid = 1; req_write = w; req_cpu = cpu[0:0]; req_addr = a; req_wdata = d;
    waits = 0;
    #1;
    while (req_wait) begin @(negedge clk); #1; waits++; end
    r = rd_data;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; int wt;
    bus(1, cpu, a, d, r, wt);
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] r);
    int wt;
    bus(0, cpu, a, 0, r, wt);
  endtask

  task automatic register(input int cpu, input bit whole, input bit notify, input int op,
                          input logic [31:0] a, input logic [31:0] s, output logic [31:0] r);
    wr(cpu, MODE, mode_word(whole, notify, op));
    wr(cpu, ADDR, a);
    wr(cpu, SIZE, s);
    rd(cpu, RES, r);
  endtask

  task automatic measure(output int gap, output int len, output logic [31:0] a0,
                         output logic [31:0] a1, output int op);
    gap = 0; len = 0; a1 = '0;
    forever begin @(negedge clk); if (exec_busy) break; gap++; end
    a0 = exec_addr; op = exec_op; len = 1;
    forever begin
      @(negedge clk);
      if (!exec_busy) break;
      len++;
      if (len == CPL + 1) a1 = exec_addr;
    end
  endtask

  task automatic run_one(input string tag, input int cpu, input bit whole, input int op,
                         input logic [31:0] a, input logic [31:0] s);
    logic [31:0] r, a0, a1; int gap, len, eop, n;
    n = lines_of(whole, s);
    register(cpu, whole, 1, op, a, s, r);
    chk({tag, " R3 accepted"}, r, 0);
    measure(gap, len, a0, a1, eop);
    chk({tag, " R5 start gap"}, gap, 1);
    chk({tag, whole ? " R6 busy length" : " R5 busy length"}, len, n * CPL);
    chk({tag, " R11 first line"}, a0, whole ? 0 : (a & ~32'(LINE - 1)));
    chk({tag, " R11 op"}, eop, op);
    if (n >= 2) chk({tag, " R11 second line"}, a1, (whole ? 0 : (a & ~32'(LINE - 1))) + LINE);
    rd(cpu, STAT, r);
    chk({tag, " R8 done flag"}, r, 4);
    wr(cpu, STAT, 4);
    rd(cpu, STAT, r);
    chk({tag, " R8 cleared"}, r, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] r, a0, a1; int wt, gap, len, eop;
    logic [31:0] starts [$];
    logic prev;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    for (int c = 0; c < NCPU; c++) begin
      rd(c, STAT, r); chk("R1 status after reset", r, 0);
      rd(c, RES, r);  chk("R1 result after reset", r, 0);
    end
    chk("R1 executor idle", exec_busy, 0);

    run_one("range", 0, 0, 1, 32'h1008, 70);
    run_one("whole", 1, 1, 2, 32'h2000, 9);

    wr(0, MODE, mode_word(0, 1, 1));
    wr(1, MODE, mode_word(1, 1, 0));
    wr(0, ADDR, 32'h400);
    wr(1, SIZE, 320);
    wr(0, SIZE, 64);
    rd(1, RES, r); chk("R2 contender result", r, 1);
    rd(0, RES, r); chk("R3 holder result", r, 0);
    measure(gap, len, a0, a1, eop);
    chk("R2 contender size ignored", len, 2 * CPL);
    chk("R2 holder address kept", a0, 32'h400);
    chk("R2 holder op kept", eop, 1);
    rd(1, STAT, r); chk("R8 other cpu no flag", r, 0);
    rd(0, STAT, r); chk("R8 owner flag", r, 4);
    wr(0, STAT, 4);
    run_one("R3 relock", 1, 0, 0, 32'h800, 32);

    register(0, 1, 1, 2, 0, 0, r);
    chk("R3 whole accepted", r, 0);
    repeat (3) @(negedge clk);
    rd(0, STAT, r); chk("R9 owner busy+exec", r, 3);
    rd(1, STAT, r); chk("R9 other busy only", r, 1);
    wr(1, PRIM, 8);
    bus(0, 1, PRIM, 0, r, wt);
    chk("R10 drain code", r, 8);
    chk("R10 stalled", wt > 10, 1);
    chk("R10 idle at release", exec_busy, 0);
    rd(0, STAT, r); chk("R10 idle after drain", r, 4);
    wr(0, STAT, 4);
    wr(0, PRIM, 2);
    bus(0, 0, PRIM, 0, r, wt);
    chk("R10 plain code", r, 2);
    chk("R10 no stall", wt, 0);

    for (int k = 1; k <= DEPTH + 2; k++) begin
      register(0, 0, 0, 0, 32'(k * 32'h1000), 32'(LINE * 40), r);
      chk("R4 registration", r, (k <= DEPTH + 1) ? 0 : 3);
    end
    wr(1, MODE, mode_word(0, 0, 0));
    rd(1, RES, r);
    chk("R4 lock freed after full", r, 3);
    prev = exec_busy;
    if (exec_busy) starts.push_back(32'h1000);
    for (int t = 0; t < (DEPTH + 2) * 90; t++) begin
      @(negedge clk);
      if (exec_busy && !prev) starts.push_back(exec_addr);
      prev = exec_busy;
    end
    chk("R7 run count", starts.size(), DEPTH + 1);
    for (int k = 0; k < starts.size(); k++) chk("R7 order", starts[k], (k + 1) * 32'h1000);
    rd(0, STAT, r); chk("R8 no notify no flag", r, 0);

    for (int i = 0; i < 20; i++) begin
      run_one("rand", int'($urandom % NCPU), ($urandom % 5) == 0, int'($urandom % 3),
              $urandom, $urandom % 300);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule